// File: doc/BRIEF.md
# CAN Controller Interrupt Status and Clear Logic

This block holds the interrupt causes of a CAN controller. Three one-cycle event strobes from the protocol engine mark the controller entering sleep, waking into normal mode and dropping into bus-off. Two FIFO fill counts, compared against two programmable watermarks, give three level causes. Each cause is captured in one bit of a 32-bit status word.

Software reads the status word at its own address and clears bits by writing ones to a separate clear address. A level cause is set again on every cycle its condition holds, so clearing it only lasts once the condition has gone away. An event cause stays cleared until its next strobe. Writing the core enable bit to 0 also wipes all three event bits. A single interrupt line is raised whenever a status bit and its enable bit are both 1.

The register port is a single-cycle write strobe with a combinational read. Word address map: 0 control (bit 0 core enable), 1 status (read-only), 2 interrupt enable, 3 clear (write-one-to-clear, reads 0), 4 transmit empty watermark, 5 receive full watermark.

Top module: `can_irq_status`

## Requirements
- R1: After reset the status word reads 0x0000_6000 (bits 14 and 13 set, all others 0). The enable, control and watermark registers read 0, and `irq` is 0.
- R2: Status bits 31:15 and 8:0 always read 0.
- R3: Status bit 14 (transmit FIFO empty) is set on every cycle that `txFill` is 0. A clear only lasts while `txFill` is non-zero.
- R4: Status bit 13 (transmit watermark) is set on every cycle that the free slot count `FIFO_DEPTH - txFill` is strictly greater than the transmit watermark.
- R5: Status bit 12 (receive watermark) is set on every cycle that `rxFill` is strictly greater than the receive watermark.
- R6: A pulse on `evWake`, `evSleep` or `evBusOff` sets status bit 11, 10 or 9 respectively. The bit then holds until it is cleared.
- R7: Writing to address 3 clears every status bit whose position has a 1 in the written data. Zeros and ones at positions outside 14:9 have no effect. Address 3 reads 0.
- R8: A write of 0 to bit 0 at address 0 clears status bits 11:9 and leaves bits 14:12 untouched. Address 0 reads back the stored enable bit.
- R9: When a set condition and a clear (address 3 write, or core enable written to 0) hit the same bit in the same cycle, the bit ends up 1.
- R10: `irq` is 1 exactly when some bit is 1 in both the status word and the enable register. The enable register stores only bits 14:9, and those are the bits it reads back.
- R11: Writes to the status address (1) change nothing.
- R12: The watermark registers at addresses 4 and 5 store the low 7 bits of the write data and read them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| txFill | input | 7 | Entries currently held in the transmit FIFO |
| rxFill | input | 7 | Entries currently held in the receive FIFO |
| evSleep | input | 1 | Strobe: controller entered sleep mode |
| evWake | input | 1 | Strobe: controller went from sleep to normal mode |
| evBusOff | input | 1 | Strobe: controller entered bus-off |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on one status bit in the same cycle: a cause setting it, and a software clear wiping it. The bench provokes this in three ways. It writes a clear for bit 14 while the transmit FIFO is empty. It fires a bus-off strobe in the same cycle as a clear write for bit 9. It fires a sleep strobe in the same cycle as the core enable being written to 0. In each case the status read on the following cycle must show the contested bit still set, while uncontested bits hit by the same clear must read 0.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int STAT_W     = 32;
  localparam int BIT_TXEMPTY = 14;
  localparam int BIT_TXWM    = 13;
  localparam int BIT_RXWM    = 12;
  localparam int BIT_WAKE    = 11;
  localparam int BIT_SLEEP   = 10;
  localparam int BIT_BUSOFF  = 9;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_MASK = 3'd2,
    RA_CLR  = 3'd3,
    RA_TXWM = 3'd4,
    RA_RXWM = 3'd5
  } regAddr_e;

  // Decoded write strobes from control to datapath
  typedef struct packed {
    logic ctrlWr;
    logic coreOff;
    logic maskWr;
    logic clrWr;
    logic txWmWr;
    logic rxWmWr;
  } regStrobe_t;
endpackage

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic       wrBit0,
  output regStrobe_t strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regAddr_e'(addr))
        RA_CTRL: begin
          strb.ctrlWr  = 1'b1;
          strb.coreOff = ~wrBit0;
        end
        RA_MASK: strb.maskWr = 1'b1;
        RA_CLR:  strb.clrWr  = 1'b1;
        RA_TXWM: strb.txWmWr = 1'b1;
        RA_RXWM: strb.rxWmWr = 1'b1;
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/can_irq_dpath.sv
module can_irq_dpath
  import can_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int WM_W       = 7,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [31:0]       wrData,
  input  logic [2:0]        rdAddr,
  input  logic [CNT_W-1:0]  txFill,
  input  logic [CNT_W-1:0]  rxFill,
  input  logic              evSleep,
  input  logic              evWake,
  input  logic              evBusOff,
  output logic [31:0]       rdData,
  output logic              irq,
  output logic [31:0]       statusVec,
  output logic [31:0]       maskVec,
  output logic [WM_W-1:0]   rxWm
);
  localparam logic [31:0] IMPL_MASK =
    (32'(1) << (BIT_TXEMPTY + 1)) - (32'(1) << BIT_BUSOFF);
  localparam logic [31:0] EVENT_MASK =
    (32'(1) << (BIT_WAKE + 1)) - (32'(1) << BIT_BUSOFF);
  localparam logic [31:0] RST_STATUS =
    (32'(1) << BIT_TXEMPTY) | (32'(1) << BIT_TXWM);

  logic [31:0]      statusQ, maskQ, setVec, clrVec;
  logic             coreEnQ;
  logic [WM_W-1:0]  txWmQ, rxWmQ;
  logic [CNT_W-1:0] txFree;

  assign txFree = CNT_W'(FIFO_DEPTH) - txFill;

  always_comb begin
    setVec = '0;
    setVec[BIT_TXEMPTY] = (txFill == '0);
    setVec[BIT_TXWM]    = (32'(txFree) > 32'(txWmQ));
    setVec[BIT_RXWM]    = (32'(rxFill) > 32'(rxWmQ));
    setVec[BIT_WAKE]    = evWake;
    setVec[BIT_SLEEP]   = evSleep;
    setVec[BIT_BUSOFF]  = evBusOff;
    clrVec = '0;
    if (strb.clrWr)   clrVec = clrVec | (wrData & IMPL_MASK);
    if (strb.coreOff) clrVec = clrVec | EVENT_MASK;
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= RST_STATUS;
    else       statusQ <= (setVec | (statusQ & ~clrVec)) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      coreEnQ <= 1'b0;
      txWmQ   <= '0;
      rxWmQ   <= '0;
    end else begin
      if (strb.maskWr) maskQ   <= wrData & IMPL_MASK;
      if (strb.ctrlWr) coreEnQ <= wrData[0];
      if (strb.txWmWr) txWmQ   <= wrData[WM_W-1:0];
      if (strb.rxWmWr) rxWmQ   <= wrData[WM_W-1:0];
    end
  end

  always_comb begin
    case (regAddr_e'(rdAddr))
      RA_CTRL: rdData = 32'(coreEnQ);
      RA_STAT: rdData = statusQ;
      RA_MASK: rdData = maskQ;
      RA_TXWM: rdData = 32'(txWmQ);
      RA_RXWM: rdData = 32'(rxWmQ);
      default: rdData = '0;
    endcase
  end

  assign irq       = |(statusQ & maskQ);
  assign statusVec = statusQ;
  assign maskVec   = maskQ;
  assign rxWm      = rxWmQ;
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
  import can_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int WM_W       = 7,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic [CNT_W-1:0] txFill,
  input  logic [CNT_W-1:0] rxFill,
  input  logic             evSleep,
  input  logic             evWake,
  input  logic             evBusOff,
  output logic             irq
);
  regStrobe_t      strb;
  logic [31:0]     statusVec, maskVec;
  logic [WM_W-1:0] rxWm;

  can_irq_ctrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrBit0 (wrData[0]),
    .strb   (strb)
  );

  can_irq_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .WM_W(WM_W), .CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .rdAddr    (addr),
    .txFill    (txFill),
    .rxFill    (rxFill),
    .evSleep   (evSleep),
    .evWake    (evWake),
    .evBusOff  (evBusOff),
    .rdData    (rdData),
    .irq       (irq),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .rxWm      (rxWm)
  );
endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int WM_W  = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic [31:0]      wrData,
  input logic [CNT_W-1:0] txFill,
  input logic [CNT_W-1:0] rxFill,
  input logic             evSleep,
  input logic             evWake,
  input logic             evBusOff,
  input logic [31:0]      statusVec,
  input logic [31:0]      maskVec,
  input logic [WM_W-1:0]  rxWm,
  input logic             irq
);
  p_reserved_r2: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[31:15] == '0) && (statusVec[8:0] == '0));

  p_txempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txFill == '0) |=> statusVec[BIT_TXEMPTY]);

  p_rxwm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (32'(rxFill) > 32'(rxWm)) |=> statusVec[BIT_RXWM]);

  p_sleep_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    evSleep |=> statusVec[BIT_SLEEP]);

  p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[BIT_WAKE] && !(wrEn && addr == RA_CLR && wrData[BIT_WAKE])
      && !(wrEn && addr == RA_CTRL && !wrData[0])) |=> statusVec[BIT_WAKE]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == RA_CLR && wrData[BIT_WAKE] && !evWake) |=> !statusVec[BIT_WAKE]);

  p_coreoff_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == RA_CTRL && !wrData[0] && !evWake && !evSleep && !evBusOff)
      |=> (statusVec[11:9] == 3'b000));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evBusOff && wrEn && addr == RA_CLR && wrData[BIT_BUSOFF]) |=> statusVec[BIT_BUSOFF]);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irq);
endmodule

bind can_irq_status can_irq_chk #(.CNT_W(CNT_W), .WM_W(WM_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .txFill    (txFill),
  .rxFill    (rxFill),
  .evSleep   (evSleep),
  .evWake    (evWake),
  .evBusOff  (evBusOff),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .rxWm      (rxWm),
  .irq       (irq)
);

// File: tb/can_irq_status_test.sv
module can_irq_status_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [6:0]  txFill = '0;
  logic [6:0]  rxFill = '0;
  logic        evSleep = 1'b0, evWake = 1'b0, evBusOff = 1'b0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  logic chkValid = 1'b0;
  logic done = 1'b0;
  logic [31:0] expQ[$];
  bit          kindQ[$];
  string       reqQ[$];

  always #10 clk = ~clk;

  can_irq_status uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .txFill(txFill), .rxFill(rxFill),
    .evSleep(evSleep), .evWake(evWake), .evBusOff(evBusOff), .irq(irq)
  );

  // monitor: compares 8 ns after each falling edge
  always begin
    @(negedge clk);
    #8;
    if (chkValid && expQ.size() > 0) begin
      logic [31:0] expV, actV;
      bit          kind;
      string       req;
      expV = expQ.pop_front();
      kind = kindQ.pop_front();
      req  = reqQ.pop_front();
      actV = kind ? {31'b0, irq} : rdData;
      compared++;
      if (actV !== expV) begin
        mismatched++;
        $display("FAIL %s: %s actual 0x%08h expected 0x%08h",
                 req, kind ? "irq" : "rdData", actV, expV);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    chkValid = 1'b0;
    wrEn = 1'b0;
    evSleep = 1'b0;
    evWake = 1'b0;
    evBusOff = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    tick();
    addr = a; wrData = d; wrEn = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    tick();
    addr = a;
    expQ.push_back(e); kindQ.push_back(1'b0); reqQ.push_back(req);
    chkValid = 1'b1;
  endtask

  task automatic irqChk(input logic e, input string req);
    tick();
    expQ.push_back({31'b0, e}); kindQ.push_back(1'b1); reqQ.push_back(req);
    chkValid = 1'b1;
  endtask

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_MASK = 3'd2,
                         A_CLR = 3'd3, A_TXWM = 3'd4, A_RXWM = 3'd5;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(A_STAT, 32'h6000, "R1");
    rd(A_MASK, 32'h0, "R1");
    rd(A_CTRL, 32'h0, "R1");
    rd(A_TXWM, 32'h0, "R1");
    irqChk(1'b0, "R1");
    rd(A_CLR, 32'h0, "R7");
    // R12 watermarks
    wr(A_TXWM, 32'd40);
    wr(A_RXWM, 32'd10);
    rd(A_TXWM, 32'd40, "R12");
    rd(A_RXWM, 32'd10, "R12");
    wr(A_TXWM, 32'hFFFF_FFA8);
    rd(A_TXWM, 32'd40, "R12");
    // R3/R4 transmit level causes
    tick(); txFill = 7'd30;
    rd(A_STAT, 32'h6000, "R3");
    wr(A_CLR, 32'h6000);
    rd(A_STAT, 32'h0, "R7");
    tick(); txFill = 7'd24;
    rd(A_STAT, 32'h0, "R4");
    tick(); txFill = 7'd23;
    rd(A_STAT, 32'h2000, "R4");
    tick(); txFill = 7'd0;
    rd(A_STAT, 32'h6000, "R3");
    wr(A_CLR, 32'h4000);
    rd(A_STAT, 32'h6000, "R3");
    // R5 receive watermark
    tick(); rxFill = 7'd10;
    rd(A_STAT, 32'h6000, "R5");
    tick(); rxFill = 7'd11;
    rd(A_STAT, 32'h7000, "R5");
    tick(); rxFill = 7'd0;
    wr(A_CLR, 32'h1000);
    rd(A_STAT, 32'h6000, "R5");
    // R6 events
    tick(); evSleep = 1'b1;
    rd(A_STAT, 32'h6400, "R6");
    rd(A_STAT, 32'h6400, "R6");
    tick(); evWake = 1'b1;
    rd(A_STAT, 32'h6C00, "R6");
    tick(); evBusOff = 1'b1;
    rd(A_STAT, 32'h6E00, "R6");
    // R7 clear behaviour, R2 reserved
    wr(A_CLR, 32'h0);
    rd(A_STAT, 32'h6E00, "R7");
    wr(A_CLR, 32'hFFFF_81FF);
    rd(A_STAT, 32'h6E00, "R2");
    rd(A_CLR, 32'h0, "R7");
    wr(A_CLR, 32'h0400);
    rd(A_STAT, 32'h6A00, "R7");
    // R11 status write ignored
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h6A00, "R11");
    // R8 core enable
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, 32'h1, "R8");
    rd(A_STAT, 32'h6A00, "R8");
    tick(); rxFill = 7'd11;
    wr(A_CTRL, 32'h0);
    rd(A_STAT, 32'h7000, "R8");
    rd(A_CTRL, 32'h0, "R8");
    // R9 set beats clear
    tick(); evBusOff = 1'b1; addr = A_CLR; wrData = 32'h0200; wrEn = 1'b1;
    rd(A_STAT, 32'h7200, "R9");
    tick(); evSleep = 1'b1; addr = A_CTRL; wrData = 32'h0; wrEn = 1'b1;
    rd(A_STAT, 32'h7400, "R9");
    // R10 interrupt output
    irqChk(1'b0, "R10");
    wr(A_MASK, 32'h0400);
    irqChk(1'b1, "R10");
    rd(A_MASK, 32'h0400, "R10");
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h7E00, "R10");
    wr(A_MASK, 32'h0400);
    wr(A_CLR, 32'h0400);
    rd(A_STAT, 32'h7000, "R10");
    irqChk(1'b0, "R10");
    wr(A_MASK, 32'h1000);
    irqChk(1'b1, "R10");
    tick(); rxFill = 7'd0;
    wr(A_CLR, 32'h1000);
    irqChk(1'b0, "R10");
    tick();
    tick();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule